// File: doc/BRIEF.md
# Peripheral Command Channel Engine

This block is one channel of a bus arbiter. A host starts a transaction toward a peripheral by writing one register. Before that, the host loads up to eight bytes of outgoing data into two data words. The command word carries an opcode, the low byte of the register address and a byte count. The engine latches the channel's slave ID and upper address byte from plain configuration pins. It then presents one request on a valid/ready port and waits for a response on a second valid/ready port. The outcome is reported in a four-flag status word that the host polls.

The engine checks each command before anything leaves the block. Opcodes it does not know are refused. Write-class opcodes issued from an execution environment that does not own the channel are also refused. Both refusals complete in the next cycle and no request is raised. A time-out counter guarantees completion. A request that is never accepted, or a response that never comes, ends with the dropped flag after a fixed number of cycles. This keeps a polling host from waiting forever.

Back-pressure rules on the peripheral side:
- Once `req_valid` rises, it stays high with all request fields unchanged until `req_ready` is seen high at a clock edge. The only exception is the time-out, which withdraws the request.
- `rsp_ready` is high only while the engine waits for a response, and never in the same cycle as `req_valid`.
- A response offered at any other time is not taken.

Top module: `cmd_chan_engine`

## Requirements
- R1: After reset the engine is idle, `req_valid`, `rsp_ready` and `chan_busy` are low, and every host-readable word reads as zero.
- R2: The host writes the command to word index 0. The opcode is in bits 31:27, the low address byte in bits 11:4 and the byte count minus one in bits 2:0.
  - In the cycle after an accepted command write, `req_valid` is high. `req_op` carries the opcode, `req_addr` is {`chan_addr_hi`, low byte}, `req_len` is the count field and `req_sid` is `chan_sid`.
  - Word 0 reads back the last command word written while idle.
- R3: `req_valid` holds, with stable request fields, until `req_ready` is seen high at a clock edge or the time-out fires. After acceptance, `rsp_ready` is high until `rsp_valid` is seen, and never together with `req_valid`.
- R4: Word 2 holds outgoing bytes 0 to 3 and word 3 holds bytes 4 to 7, lowest byte in bits 7:0. `req_wdata` presents byte i at bits 8i+7:8i.
- R5: For the read-class opcodes 1, 8, 13 and 15, a response without error is stored in word 4 (bytes 0 to 3) and word 5 (bytes 4 to 7). Bytes above the count are stored as zero. Other opcodes, and responses with error, leave words 4 and 5 unchanged.
- R6: The status word is at index 1: bit 0 done, bit 1 failure, bit 2 denied, bit 3 dropped.
  - An accepted command clears the status, and it stays zero while busy.
  - A response sets done, and also sets failure when `rsp_err` is high.
- R7: Write-class opcodes 0, 2, 9, 14 and 16 issued while `chan_owner` differs from `local_env` raise no request. The status becomes 0x5 (done and denied) in the next cycle. Other opcodes are not subject to the ownership check.
- R8: Opcodes 10, 11, 12 and 17 to 31 raise no request, and the status becomes 0x3 (done and failure) in the next cycle.
- R9: A transaction without a response ends with status 0x9 (done and dropped), and the engine returns to idle.
  - If the request is never accepted, the engine is busy for exactly TIMEOUT_CYC cycles.
  - If no response follows acceptance, the engine is also busy for exactly TIMEOUT_CYC cycles.
  - No transaction stays busy for more than TIMEOUT_CYC+1 cycles.
- R10: While busy, host writes to the command word and to the data words are ignored.
- R11: An error flag is never set without done, and at most one error flag is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | HADDR_W | Word index of the host write |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | HADDR_W | Word index of the host read |
| host_rdata | output | 32 | Read data for `host_raddr` (combinational) |
| chan_owner | input | ENV_W | Environment that owns writes on this channel |
| local_env | input | ENV_W | Environment issuing the commands |
| chan_sid | input | SID_W | Slave ID of the channel's peripheral |
| chan_addr_hi | input | AHI_W | Upper address byte of the channel's peripheral |
| chan_busy | output | 1 | A transaction is in flight |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Peripheral accepts the request |
| req_op | output | 5 | Request opcode |
| req_sid | output | SID_W | Request slave ID |
| req_addr | output | AHI_W+8 | Request register address |
| req_len | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Outgoing bytes, byte 0 lowest |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Engine accepts a response |
| rsp_err | input | 1 | Response reports failure |
| rsp_rdata | input | 64 | Returned bytes, byte 0 lowest |

## Verification
Several properties are checked by assertions on every cycle:
- request stability under back-pressure, and the exclusion of `rsp_ready` against `req_valid`;
- error flags always paired with done, with at most one error flag;
- zero status while busy, and the busy-length bound;
- the one-cycle refusal of a non-owner write and of an unknown opcode.

Other behaviours only the bench scenarios can show:
- field packing into the request;
- byte ordering and masking of read data;
- read data left untouched on errors and non-read opcodes;
- the exact time-out length in each phase;
- host writes ignored while busy.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int OP_W    = 5;
  localparam int LEN_W   = 3;
  localparam int ALO_W   = 8;
  localparam int ST_W    = 4;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = 8;
  localparam int DATA_W  = NBYTES * 8;

  // command word field positions (decoded by the peripheral path)
  localparam int OP_LSB  = 27;
  localparam int ALO_LSB = 4;
  localparam int LEN_LSB = 0;

  // host word indices
  localparam int REG_CMD  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_WLO  = 2;
  localparam int REG_WHI  = 3;
  localparam int REG_RLO  = 4;
  localparam int REG_RHI  = 5;

  // status codes: bit0 done, bit1 failure, bit2 denied, bit3 dropped
  localparam logic [ST_W-1:0] ST_CLEAR   = 4'b0000;
  localparam logic [ST_W-1:0] ST_OK      = 4'b0001;
  localparam logic [ST_W-1:0] ST_FAILED  = 4'b0011;
  localparam logic [ST_W-1:0] ST_DENIED  = 4'b0101;
  localparam logic [ST_W-1:0] ST_DROPPED = 4'b1001;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic known;
    logic writes;
    logic reads;
  } op_class_t;
endpackage

// File: rtl/cce_opdec.sv
module cce_opdec
  import cce_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_class_t       cls_o
);
  always_comb begin
    cls_o = '0;
    case (op_i)
      5'd0, 5'd2, 5'd9, 5'd14, 5'd16: begin
        cls_o.known  = 1'b1;
        cls_o.writes = 1'b1;
      end
      5'd1, 5'd8, 5'd13, 5'd15: begin
        cls_o.known = 1'b1;
        cls_o.reads = 1'b1;
      end
      5'd3, 5'd4, 5'd5, 5'd6, 5'd7: begin
        cls_o.known = 1'b1;
      end
      default: cls_o = '0;
    endcase
  end
endmodule

// File: rtl/cce_seq.sv
module cce_seq
  import cce_pkg::*;
#(
  parameter int ENV_W       = 3,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  op_class_t        cls_i,
  input  logic [ENV_W-1:0] owner_i,
  input  logic [ENV_W-1:0] local_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_err_i,
  output phase_e           phase_o,
  output logic [ST_W-1:0]  stat_o,
  output logic             start_o,
  output logic             capture_o
);
  localparam int TIM_W = $clog2(TIMEOUT_CYC + 2);
  localparam logic [TIM_W-1:0] TIM_LAST = TIM_W'(TIMEOUT_CYC - 1);

  phase_e            ph_q;
  logic [TIM_W-1:0]  tim_q;
  logic [ST_W-1:0]   st_q;
  logic              rd_q;
  logic              refuse_own;
  logic              expired;
  logic              idle_cmd;

  assign refuse_own = cls_i.writes && (owner_i != local_i);
  assign idle_cmd   = cmd_wr_i && (ph_q == PH_IDLE);
  assign start_o    = idle_cmd && cls_i.known && !refuse_own;
  assign expired    = (tim_q >= TIM_LAST);
  assign capture_o  = (ph_q == PH_WAIT) && rsp_valid_i && !rsp_err_i && rd_q;
  assign phase_o    = ph_q;
  assign stat_o     = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tim_q <= '0;
      st_q  <= ST_CLEAR;
      rd_q  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (idle_cmd) begin
            tim_q <= '0;
            if (!cls_i.known) begin
              st_q <= ST_FAILED;
            end else if (refuse_own) begin
              st_q <= ST_DENIED;
            end else begin
              st_q <= ST_CLEAR;
              rd_q <= cls_i.reads;
              ph_q <= PH_REQ;
            end
          end
        end
        PH_REQ: begin
          // acceptance wins over expiry: a taken request always gets its wait phase
          if (req_ready_i) begin
            ph_q  <= PH_WAIT;
            tim_q <= tim_q + 1'b1;
          end else if (expired) begin
            st_q <= ST_DROPPED;
            ph_q <= PH_IDLE;
          end else begin
            tim_q <= tim_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (rsp_valid_i) begin
            st_q <= rsp_err_i ? ST_FAILED : ST_OK;
            ph_q <= PH_IDLE;
          end else if (expired) begin
            st_q <= ST_DROPPED;
            ph_q <= PH_IDLE;
          end else begin
            tim_q <= tim_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cce_datapath.sv
module cce_datapath
  import cce_pkg::*;
#(
  parameter int HADDR_W = 3,
  parameter int SID_W   = 4,
  parameter int AHI_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we_i,
  input  logic [HADDR_W-1:0]     host_waddr_i,
  input  logic [WORD_W-1:0]      host_wdata_i,
  input  logic [HADDR_W-1:0]     host_raddr_i,
  output logic [WORD_W-1:0]      host_rdata_o,
  input  logic                   idle_i,
  input  logic                   start_i,
  input  logic                   capture_i,
  input  logic [ST_W-1:0]        stat_i,
  input  logic [SID_W-1:0]       sid_i,
  input  logic [AHI_W-1:0]       ahi_i,
  input  logic [DATA_W-1:0]      rsp_rdata_i,
  output logic [OP_W-1:0]        req_op_o,
  output logic [SID_W-1:0]       req_sid_o,
  output logic [AHI_W+ALO_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]       req_len_o,
  output logic [DATA_W-1:0]      req_wdata_o
);
  logic [WORD_W-1:0] cmd_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_w;
  logic [SID_W-1:0]  sid_q;
  logic [AHI_W-1:0]  ahi_q;
  logic [LEN_W-1:0]  len_w;
  logic              wr_ok;

  assign wr_ok = host_we_i && idle_i;
  assign len_w = cmd_q[LEN_LSB +: LEN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wd_q  <= '0;
      sid_q <= '0;
      ahi_q <= '0;
    end else begin
      if (wr_ok && host_waddr_i == HADDR_W'(REG_CMD))
        cmd_q <= host_wdata_i;
      if (wr_ok && host_waddr_i == HADDR_W'(REG_WLO))
        wd_q[WORD_W-1:0] <= host_wdata_i;
      if (wr_ok && host_waddr_i == HADDR_W'(REG_WHI))
        wd_q[DATA_W-1:WORD_W] <= host_wdata_i;
      if (start_i) begin
        sid_q <= sid_i;
        ahi_q <= ahi_i;
      end
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_rbyte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= 8'h00;
      else if (capture_i)
        byte_q <= (LEN_W'(b) <= len_w) ? rsp_rdata_i[b*8 +: 8] : 8'h00;
    end
    assign rd_w[b*8 +: 8] = byte_q;
  end

  always_comb begin
    case (host_raddr_i)
      HADDR_W'(REG_CMD):  host_rdata_o = cmd_q;
      HADDR_W'(REG_STAT): host_rdata_o = {{(WORD_W-ST_W){1'b0}}, stat_i};
      HADDR_W'(REG_WLO):  host_rdata_o = wd_q[WORD_W-1:0];
      HADDR_W'(REG_WHI):  host_rdata_o = wd_q[DATA_W-1:WORD_W];
      HADDR_W'(REG_RLO):  host_rdata_o = rd_w[WORD_W-1:0];
      HADDR_W'(REG_RHI):  host_rdata_o = rd_w[DATA_W-1:WORD_W];
      default:            host_rdata_o = '0;
    endcase
  end

  assign req_op_o    = cmd_q[OP_LSB +: OP_W];
  assign req_len_o   = len_w;
  assign req_addr_o  = {ahi_q, cmd_q[ALO_LSB +: ALO_W]};
  assign req_sid_o   = sid_q;
  assign req_wdata_o = wd_q;
endmodule

// File: rtl/cmd_chan_engine.sv
module cmd_chan_engine
  import cce_pkg::*;
#(
  parameter int HADDR_W     = 3,
  parameter int ENV_W       = 3,
  parameter int SID_W       = 4,
  parameter int AHI_W       = 8,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [HADDR_W-1:0]     host_waddr,
  input  logic [31:0]            host_wdata,
  input  logic [HADDR_W-1:0]     host_raddr,
  output logic [31:0]            host_rdata,
  input  logic [ENV_W-1:0]       chan_owner,
  input  logic [ENV_W-1:0]       local_env,
  input  logic [SID_W-1:0]       chan_sid,
  input  logic [AHI_W-1:0]       chan_addr_hi,
  output logic                   chan_busy,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [4:0]             req_op,
  output logic [SID_W-1:0]       req_sid,
  output logic [AHI_W+7:0]       req_addr,
  output logic [2:0]             req_len,
  output logic [63:0]            req_wdata,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic                   rsp_err,
  input  logic [63:0]            rsp_rdata
);
  op_class_t        cls;
  phase_e           phase;
  logic [ST_W-1:0]  stat_q;
  logic             start;
  logic             capture;
  logic             cmd_wr;

  assign cmd_wr = host_we && (host_waddr == HADDR_W'(REG_CMD));

  cce_opdec u_opdec (
    .op_i  (host_wdata[OP_LSB +: OP_W]),
    .cls_o (cls)
  );

  cce_seq #(
    .ENV_W       (ENV_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (cmd_wr),
    .cls_i       (cls),
    .owner_i     (chan_owner),
    .local_i     (local_env),
    .req_ready_i (req_ready),
    .rsp_valid_i (rsp_valid),
    .rsp_err_i   (rsp_err),
    .phase_o     (phase),
    .stat_o      (stat_q),
    .start_o     (start),
    .capture_o   (capture)
  );

  cce_datapath #(
    .HADDR_W (HADDR_W),
    .SID_W   (SID_W),
    .AHI_W   (AHI_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we_i    (host_we),
    .host_waddr_i (host_waddr),
    .host_wdata_i (host_wdata),
    .host_raddr_i (host_raddr),
    .host_rdata_o (host_rdata),
    .idle_i       (phase == PH_IDLE),
    .start_i      (start),
    .capture_i    (capture),
    .stat_i       (stat_q),
    .sid_i        (chan_sid),
    .ahi_i        (chan_addr_hi),
    .rsp_rdata_i  (rsp_rdata),
    .req_op_o     (req_op),
    .req_sid_o    (req_sid),
    .req_addr_o   (req_addr),
    .req_len_o    (req_len),
    .req_wdata_o  (req_wdata)
  );

  assign req_valid = (phase == PH_REQ);
  assign rsp_ready = (phase == PH_WAIT);
  assign chan_busy = (phase != PH_IDLE);
endmodule

// File: rtl/cce_checker.sv
module cce_checker #(
  parameter int HADDR_W     = 3,
  parameter int SID_W       = 4,
  parameter int AHI_W       = 8,
  parameter int TIMEOUT_CYC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [HADDR_W-1:0] host_waddr,
  input logic [31:0]        host_wdata,
  input logic               owner_differs,
  input logic               chan_busy,
  input logic               req_valid,
  input logic               req_ready,
  input logic [4:0]         req_op,
  input logic [SID_W-1:0]   req_sid,
  input logic [AHI_W+7:0]   req_addr,
  input logic [2:0]         req_len,
  input logic [63:0]        req_wdata,
  input logic               rsp_ready,
  input logic [3:0]         stat_q
);
  localparam int CW = $clog2(TIMEOUT_CYC + 3);
  logic [CW-1:0] busy_cnt;
  logic          cmd_idle;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (chan_busy) busy_cnt <= busy_cnt + 1'b1;
    else                busy_cnt <= '0;
  end

  assign cmd_idle = host_we && (host_waddr == '0) && !chan_busy;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid || stat_q[3]);

  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !req_valid ||
      ($stable(req_op) && $stable(req_sid) && $stable(req_addr) &&
       $stable(req_len) && $stable(req_wdata)));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_busy |-> stat_q == 4'b0000);

  assert_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle && host_wdata[31:27] == 5'd14 && owner_differs
      |=> stat_q == 4'b0101 && !req_valid && !chan_busy);

  assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle && host_wdata[31:27] == 5'd11
      |=> stat_q == 4'b0011 && !req_valid && !chan_busy);

  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_busy |-> busy_cnt <= CW'(TIMEOUT_CYC));

  assert_err_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q[3:1]) |-> stat_q[0]);

  assert_one_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q[3:1]));
endmodule

bind cmd_chan_engine cce_checker #(
  .HADDR_W     (HADDR_W),
  .SID_W       (SID_W),
  .AHI_W       (AHI_W),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_we       (host_we),
  .host_waddr    (host_waddr),
  .host_wdata    (host_wdata),
  .owner_differs (chan_owner != local_env),
  .chan_busy     (chan_busy),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_sid       (req_sid),
  .req_addr      (req_addr),
  .req_len       (req_len),
  .req_wdata     (req_wdata),
  .rsp_ready     (rsp_ready),
  .stat_q        (stat_q)
);

// File: tb/cmd_chan_engine_tb_top.sv
module cmd_chan_engine_tb_top;
  localparam int TO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [2:0]  host_raddr = 3'd1;
  logic [31:0] host_rdata;
  logic [2:0]  chan_owner = 3'd2;
  logic [2:0]  local_env = 3'd2;
  logic [3:0]  chan_sid = 4'd5;
  logic [7:0]  chan_addr_hi = 8'hC3;
  logic        chan_busy, req_valid, rsp_ready;
  logic        req_ready = 1'b0;
  logic [4:0]  req_op;
  logic [3:0]  req_sid;
  logic [15:0] req_addr;
  logic [2:0]  req_len;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic [63:0] rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  cmd_chan_engine #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .chan_owner(chan_owner), .local_env(local_env), .chan_sid(chan_sid),
    .chan_addr_hi(chan_addr_hi), .chan_busy(chan_busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_sid(req_sid),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          m_ph = 0;   // 0 idle, 1 offering, 2 awaiting reply
  int          m_tim = 0;
  logic [3:0]  m_st = '0;
  logic [31:0] m_cmd = '0;
  logic [63:0] m_wd = '0, m_rd = '0;
  logic [3:0]  m_sid = '0;
  logic [7:0]  m_ahi = '0;
  int          m_old;

  function automatic bit is_wr(input logic [4:0] op);
    return op == 0 || op == 2 || op == 9 || op == 14 || op == 16;
  endfunction
  function automatic bit is_rd(input logic [4:0] op);
    return op == 1 || op == 8 || op == 13 || op == 15;
  endfunction
  function automatic bit is_known(input logic [4:0] op);
    return op <= 9 || (op >= 13 && op <= 16);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_tim = 0; m_st = '0; m_cmd = '0; m_wd = '0; m_rd = '0;
      m_sid = '0; m_ahi = '0;
    end else begin
      m_old = m_ph;
      if (host_we && m_old == 0) begin
        if (host_waddr == 3'd2) m_wd[31:0] = host_wdata;
        if (host_waddr == 3'd3) m_wd[63:32] = host_wdata;
        if (host_waddr == 3'd0) begin
          m_cmd = host_wdata;
          m_tim = 0;
          if (!is_known(host_wdata[31:27])) m_st = 4'h3;
          else if (is_wr(host_wdata[31:27]) && chan_owner != local_env) m_st = 4'h5;
          else begin
            m_st = 4'h0; m_ph = 1; m_sid = chan_sid; m_ahi = chan_addr_hi;
          end
        end
      end
      if (m_old == 1) begin
        if (req_ready) begin m_ph = 2; m_tim++; end
        else if (m_tim >= TO - 1) begin m_st = 4'h9; m_ph = 0; end
        else m_tim++;
      end else if (m_old == 2) begin
        if (rsp_valid) begin
          m_st = rsp_err ? 4'h3 : 4'h1;
          if (is_rd(m_cmd[31:27]) && !rsp_err)
            for (int b = 0; b < 8; b++)
              m_rd[8*b +: 8] = (b <= int'(m_cmd[2:0])) ? rsp_rdata[8*b +: 8] : 8'h00;
          m_ph = 0;
        end else if (m_tim >= TO - 1) begin m_st = 4'h9; m_ph = 0; end
        else m_tim++;
      end
    end
  end

  function automatic logic [31:0] m_word(input logic [2:0] a);
    case (a)
      3'd0: return m_cmd;
      3'd1: return {28'd0, m_st};
      3'd2: return m_wd[31:0];
      3'd3: return m_wd[63:32];
      3'd4: return m_rd[31:0];
      3'd5: return m_rd[63:32];
      default: return 32'd0;
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always begin
    logic [126:0] act, exp;
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      act = {req_valid, rsp_ready, chan_busy, host_rdata,
             req_valid ? {req_op, req_sid, req_addr, req_len, req_wdata} : 92'd0};
      exp = {m_ph == 1, m_ph == 2, m_ph != 0, m_word(host_raddr),
             (m_ph == 1) ? {m_cmd[31:27], m_sid, m_ahi, m_cmd[11:4], m_cmd[2:0], m_wd} : 92'd0};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL R3 R6 cycle model: actual=%h expected=%h", act, exp);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [7:0] a, input logic [2:0] l);
    return {op, 15'd0, a, 1'b0, l};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    host_raddr = a;
    #1 v = host_rdata;
  endtask

  task automatic serve(input int rdly, input int sdly, input bit err, input logic [63:0] d);
    repeat (rdly) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    repeat (sdly) @(negedge clk);
    rsp_valid = 1'b1; rsp_err = err; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 req_valid after reset", req_valid, 0);
    check("R1 busy after reset", chan_busy, 0);
    rd(3'd1, v); check("R1 status after reset", v, 0);
    rd(3'd4, v); check("R1 read word after reset", v, 0);

    // write long, owner matches
    wr(3'd2, 32'h44332211);
    wr(3'd3, 32'h88776655);
    wr(3'd0, mk(5'd0, 8'h5A, 3'd7));
    #1;
    check("R2 request raised", req_valid, 1);
    check("R2 opcode", req_op, 0);
    check("R2 address", req_addr, 16'hC35A);
    check("R2 length", req_len, 7);
    check("R2 slave id", req_sid, 5);
    check("R4 write bytes", req_wdata, 64'h8877665544332211);
    repeat (3) @(negedge clk);
    #1 check("R3 request held under back-pressure", req_valid, 1);
    serve(0, 1, 1'b0, 64'h0);
    #1 check("R3 idle after reply", chan_busy, 0);
    rd(3'd1, v); check("R6 done status", v, 32'h1);
    rd(3'd0, v); check("R2 command readback", v, mk(5'd0, 8'h5A, 3'd7));

    // read long, 3 bytes
    wr(3'd0, mk(5'd1, 8'h10, 3'd2));
    serve(1, 0, 1'b0, 64'hFFEEDDCCBBAA9988);
    rd(3'd4, v); check("R5 masked low word", v, 32'h00AA9988);
    rd(3'd5, v); check("R5 masked high word", v, 32'h0);

    // read with error keeps data
    wr(3'd0, mk(5'd1, 8'h10, 3'd7));
    serve(0, 0, 1'b1, 64'h0102030405060708);
    rd(3'd1, v); check("R6 failure status", v, 32'h3);
    rd(3'd4, v); check("R5 data kept on error", v, 32'h00AA9988);

    // full 8-byte read, then non-read opcode
    wr(3'd0, mk(5'd13, 8'h20, 3'd7));
    serve(0, 2, 1'b0, 64'hFFEEDDCCBBAA9988);
    rd(3'd5, v); check("R5 full high word", v, 32'hFFEEDDCC);
    wr(3'd0, mk(5'd3, 8'h00, 3'd0));
    serve(0, 0, 1'b0, 64'h1111111111111111);
    rd(3'd4, v); check("R5 non-read opcode leaves data", v, 32'hBBAA9988);

    // ownership
    chan_owner = 3'd1;
    wr(3'd0, mk(5'd14, 8'h30, 3'd0));
    #1 check("R7 no request for foreign write", req_valid, 0);
    rd(3'd1, v); check("R7 R11 denied status", v, 32'h5);
    wr(3'd0, mk(5'd15, 8'h31, 3'd0));
    #1 check("R7 reads allowed without ownership", req_valid, 1);
    serve(0, 0, 1'b0, 64'h0000000000000077);
    rd(3'd4, v); check("R7 read completed", v, 32'h77);
    chan_owner = 3'd2;

    // unknown opcodes
    wr(3'd0, mk(5'd11, 8'h00, 3'd0));
    #1 check("R8 no request for opcode 11", req_valid, 0);
    rd(3'd1, v); check("R8 failure for opcode 11", v, 32'h3);
    wr(3'd0, mk(5'd20, 8'h00, 3'd0));
    rd(3'd1, v); check("R8 failure for opcode 20", v, 32'h3);

    // time-out while offering
    host_raddr = 3'd1;
    wr(3'd0, mk(5'd1, 8'h40, 3'd0));
    n = 0;
    #1;
    while (chan_busy && n < 100) begin @(negedge clk); n++; #1; end
    check("R9 busy length, never accepted", n, TO);
    check("R9 dropped status", host_rdata, 32'h9);

    // time-out while awaiting reply
    wr(3'd0, mk(5'd1, 8'h41, 3'd0));
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    n = 1;
    #1;
    while (chan_busy && n < 100) begin @(negedge clk); n++; #1; end
    check("R9 busy length, no reply", n, TO);
    check("R9 dropped after acceptance", host_rdata, 32'h9);

    // writes ignored while busy
    wr(3'd0, mk(5'd1, 8'h50, 3'd0));
    #1 check("R6 status cleared by new command", host_rdata, 32'h0);
    wr(3'd2, 32'hDEADBEEF);
    wr(3'd0, mk(5'd11, 8'h00, 3'd0));
    #1 check("R10 still busy after command write", chan_busy, 1);
    check("R10 opcode unchanged", req_op, 1);
    serve(0, 0, 1'b0, 64'h0);
    rd(3'd1, v); check("R10 status from original command", v, 32'h1);
    rd(3'd2, v); check("R10 write data kept", v, 32'h44332211);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule